// File: doc/BRIEF.md
# Gate Driver Fault Protection Controller

This block holds the digital control for an isolated power-transistor gate driver. It is split into two sides that share a one-bit command link. The command side turns a differential input pair into a drive command. It also keeps a sticky fault latch, which is reported on an active-low fault flag and cleared by an active-low clear input. The drive side turns the command into three mutually exclusive enables for the output devices: a pull-up, a strong pull-down and a weak pull-down. These enables are shaped by an undervoltage-lockout flag, a desaturation-detect flag and a low-gate comparator flag. All analog sensing arrives as synchronous digital inputs.

When a desaturation event occurs while the command is on, the drive side latches an output fault and turns the gate off slowly through the weak pull-down. Once the gate is reported low, it clamps the gate with the strong pull-down. The output fault is carried back to the command side through a two-flop synchronizer. There it sets the sticky latch, which forces the command off. That forced-off command in turn clears the output fault. The command side stays locked until the clear input is driven low at a moment when no synchronized output fault is still present.

Top module: `gate_fault_ctrl`

## Requirements
- R1: With the command-side latch clear, `cmd_link` equals `in_pos & ~in_neg` in the same cycle and `fault_n` stays 1 whatever `flt_clr_n` does.
- R2: Once the dead gap has passed, `cmd_link`=1 gives the enable pattern pull-up only and `cmd_link`=0 gives strong pull-down only. The pattern changes one clock edge after the command changes, and that first cycle is the dead gap.
- R3: `pu_en` is never 1 in the same cycle as either pull-down enable, and every change of drive direction is preceded by at least DEAD_CYC cycles with all three enables 0.
- R4: Undervoltage lockout outranks every other condition. In the cycle after `uvlo` is sampled high, `pu_en` is 0, and `pd_strong_en` turns on once any dead gap has passed. This holds even if a desaturation fault is taken on the same edge.
- R5: `desat` sampled while `cmd_link` is 0 has no effect: the strong pull-down stays on and `fault_n` stays 1.
- R6: A desaturation fault taken while the pull-up is on leads, after the dead gap, to the weak pull-down alone being enabled.
- R7: During the soft turn-off, `gate_low` sampled high moves the drive to strong pull-down only on the next cycle.
- R8: The output-side fault clears on the first edge at which `cmd_link` is 0.
- R9: An output fault taken at edge E drives `fault_n` to 0 and forces `cmd_link` to 0 from edge E+3 (one register plus two synchronizer stages).
- R10: The command-side latch holds until `flt_clr_n` is low at an edge where the synchronized output fault is 0. A clear held low while that fault is still present does not release it.
- R11: While `rst_n` is low at a clock edge, the latch and the output fault are cleared and the drive returns to strong pull-down only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| in_pos | input | 1 | Non-inverting drive input |
| in_neg | input | 1 | Inverting drive input |
| flt_clr_n | input | 1 | Active-low clear of the command-side fault latch |
| uvlo | input | 1 | Drive supply below lockout threshold |
| desat | input | 1 | Desaturation detected on the switched transistor |
| gate_low | input | 1 | Gate voltage below the low clamp threshold |
| cmd_link | output | 1 | Command carried across the isolated link |
| fault_n | output | 1 | Active-low latched fault flag |
| pu_en | output | 1 | Pull-up enable |
| pd_strong_en | output | 1 | Strong pull-down enable |
| pd_weak_en | output | 1 | Weak pull-down enable |

## Verification
Undervoltage lockout and a desaturation fault can be taken on the same edge while the pull-up is on. The bench raises `uvlo` and `desat` together during on-time. It then expects a dead cycle, followed by strong pull-down only, never the weak pull-down, while the output fault still travels back and drops `fault_n` three edges later. A second overlap, a clear held low while the synchronized fault is still present, is judged by the exact number of cycles `fault_n` stays low.

// File: rtl/gdfp_pkg.sv
// Shared types for the gate driver fault protection controller.
// Assumes a single clock domain for the model; the link is a wire.
package gdfp_pkg;
    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_ON    = 2'd1,
        DRV_SOFT  = 2'd2,
        DRV_CLAMP = 2'd3
    } drv_state_t;
endpackage

// File: rtl/gdfp_sync.sv
// Multi-stage synchronizer carrying a level across the isolated link.
// Assumes STAGES >= 2; output delay is STAGES edges.
module gdfp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the level through the chain, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/gdfp_cmd_side.sv
// Command side: differential input decode and sticky fault latch.
// Assumes flt_remote is already synchronized; set outranks clear.
module gdfp_cmd_side (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pos,
    input  logic in_neg,
    input  logic clr_n,
    input  logic flt_remote,
    output logic cmd,
    output logic fault_n
);
    logic locked;

    // Sticky latch: set by remote fault, released only by low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) locked <= 1'b0;
        else        locked <= flt_remote | (locked & clr_n);
    end

    assign cmd     = ~locked & in_pos & ~in_neg;
    assign fault_n = ~locked;
endmodule

// File: rtl/gdfp_drive_fsm.sv
// Drive side: four-state output FSM with dead-gap insertion and
// output-fault latch. Assumes DEAD_CYC >= 1; uvlo has top priority.
module gdfp_drive_fsm
    import gdfp_pkg::*;
#(
    parameter int DEAD_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic uvlo,
    input  logic desat,
    input  logic gate_low,
    output logic pu_en,
    output logic pd_strong_en,
    output logic pd_weak_en,
    output logic fault_out
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    drv_state_t        state_q, state_d;
    logic              fault_q, fault_d;
    logic [DW-1:0]     dead_q;
    logic              dir_flip;

    // Output fault is taken only with the command on, and dropped when it goes off.
    assign fault_d = cmd & (fault_q | desat);

    // Next-state selection with lockout first, then fault, then command.
    always_comb begin
        state_d = state_q;
        if (uvlo) begin
            state_d = DRV_OFF;
        end else if (fault_d) begin
            case (state_q)
                DRV_ON, DRV_SOFT: state_d = gate_low ? DRV_CLAMP : DRV_SOFT;
                default:          state_d = DRV_CLAMP;
            endcase
        end else begin
            state_d = cmd ? DRV_ON : DRV_OFF;
        end
    end

    assign dir_flip = (state_d == DRV_ON) != (state_q == DRV_ON);

    // State, fault and dead-gap counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRV_OFF;
            fault_q <= 1'b0;
            dead_q  <= '0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
            if (dir_flip)          dead_q <= DW'(DEAD_CYC);
            else if (dead_q != '0) dead_q <= dead_q - 1'b1;
        end
    end

    // Enables decoded from state, all held off during the gap.
    always_comb begin
        pu_en        = 1'b0;
        pd_strong_en = 1'b0;
        pd_weak_en   = 1'b0;
        if (dead_q == '0) begin
            case (state_q)
                DRV_ON:   pu_en        = 1'b1;
                DRV_SOFT: pd_weak_en   = 1'b1;
                default:  pd_strong_en = 1'b1;
            endcase
        end
    end

    assign fault_out = fault_q;
endmodule

// File: rtl/gate_fault_ctrl.sv
// Top: joins command side and drive side through the command link and
// a synchronized fault return path. Assumes synchronous digital inputs.
module gate_fault_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYC    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pos,
    input  logic in_neg,
    input  logic flt_clr_n,
    input  logic uvlo,
    input  logic desat,
    input  logic gate_low,
    output logic cmd_link,
    output logic fault_n,
    output logic pu_en,
    output logic pd_strong_en,
    output logic pd_weak_en
);
    logic flt_drive;
    logic flt_synced;

    gdfp_cmd_side u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_pos     (in_pos),
        .in_neg     (in_neg),
        .clr_n      (flt_clr_n),
        .flt_remote (flt_synced),
        .cmd        (cmd_link),
        .fault_n    (fault_n)
    );

    gdfp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flt_drive),
        .q     (flt_synced)
    );

    gdfp_drive_fsm #(.DEAD_CYC(DEAD_CYC)) u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd_link),
        .uvlo         (uvlo),
        .desat        (desat),
        .gate_low     (gate_low),
        .pu_en        (pu_en),
        .pd_strong_en (pd_strong_en),
        .pd_weak_en   (pd_weak_en),
        .fault_out    (flt_drive)
    );
endmodule

// File: rtl/gate_fault_ctrl_checker.sv
// Checker for gate_fault_ctrl: port-level temporal properties.
// Assumes reset is asserted for at least one edge at start.
module gate_fault_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic flt_clr_n,
    input logic uvlo,
    input logic cmd_link,
    input logic fault_n,
    input logic pu_en,
    input logic pd_strong_en,
    input logic pd_weak_en
);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_en && (pd_strong_en || pd_weak_en)));

    p_gap_before_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en && !$past(pu_en)) |-> (!$past(pd_strong_en) && !$past(pd_weak_en)));

    p_gap_before_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_strong_en || pd_weak_en) |-> !$past(pu_en));

    p_single_device_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pu_en, pd_strong_en, pd_weak_en}));

    p_lockout_up_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !pu_en);

    p_lockout_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo && pd_strong_en) |=> pd_strong_en);

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && flt_clr_n) |=> !fault_n);

    p_cmd_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !cmd_link);
endmodule

bind gate_fault_ctrl gate_fault_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_clr_n    (flt_clr_n),
    .uvlo         (uvlo),
    .cmd_link     (cmd_link),
    .fault_n      (fault_n),
    .pu_en        (pu_en),
    .pd_strong_en (pd_strong_en),
    .pd_weak_en   (pd_weak_en)
);

// File: tb/gate_fault_ctrl_test.sv
module gate_fault_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_pos = 1'b0, in_neg = 1'b0, flt_clr_n = 1'b1;
    logic uvlo = 1'b0, desat = 1'b0, gate_low = 1'b0;
    logic cmd_link, fault_n, pu_en, pd_strong_en, pd_weak_en;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    localparam logic [2:0] UP = 3'b100, STRONG = 3'b010, WEAK = 3'b001, NONE = 3'b000;

    always #4 clk = ~clk;

    gate_fault_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
        .flt_clr_n(flt_clr_n), .uvlo(uvlo), .desat(desat), .gate_low(gate_low),
        .cmd_link(cmd_link), .fault_n(fault_n), .pu_en(pu_en),
        .pd_strong_en(pd_strong_en), .pd_weak_en(pd_weak_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_drv(string tag, logic [2:0] exp);
        checks++;
        if ({pu_en, pd_strong_en, pd_weak_en} !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag,
                     {pu_en, pd_strong_en, pd_weak_en}, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R11: reset state
        repeat (3) tick();
        chk_drv("R11 enables in reset", STRONG);
        chk_bit("R11 fault_n in reset", fault_n, 1'b1);
        rst_n = 1'b1;
        tick();
        chk_drv("R11 enables after reset", STRONG);

        // R1: sweep inputs and clear with no latch
        for (int v = 0; v < 8; v++) begin
            in_pos = v[0]; in_neg = v[1]; flt_clr_n = v[2];
            #1;
            chk_bit("R1 cmd_link decode", cmd_link, v[0] & ~v[1]);
            tick();
            chk_bit("R1 fault_n released", fault_n, 1'b1);
        end
        in_pos = 0; in_neg = 0; flt_clr_n = 1;
        repeat (3) tick();

        // R2/R3: turn on and off
        in_pos = 1;
        tick(); chk_drv("R3 gap before up", NONE);
        tick(); chk_drv("R2 pull-up on", UP);
        tick(); chk_drv("R2 pull-up held", UP);
        in_pos = 0;
        tick(); chk_drv("R3 gap before down", NONE);
        tick(); chk_drv("R2 strong off", STRONG);

        // R4: lockout during on-time
        in_pos = 1; tick(); tick();
        chk_drv("R4 precondition on", UP);
        uvlo = 1;
        tick(); chk_drv("R4 pull-up dropped", NONE);
        tick(); chk_drv("R4 strong clamp", STRONG);
        tick(); chk_drv("R4 clamp with command on", STRONG);
        uvlo = 0;
        tick(); chk_drv("R3 gap after lockout", NONE);
        tick(); chk_drv("R2 back on", UP);
        in_pos = 0; tick(); tick();

        // R5: desat with command off is ignored
        desat = 1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk_drv("R5 strong stays", STRONG);
            chk_bit("R5 no fault", fault_n, 1'b1);
        end
        desat = 0;

        // R6/R7/R9/R10: soft turn-off, clamp, feedback, clear
        in_pos = 1; tick(); tick();
        desat = 1;
        tick(); chk_drv("R6 gap into soft off", NONE);          // E0
        tick(); chk_drv("R6 weak only", WEAK);                  // E1
        chk_bit("R9 fault_n not yet", fault_n, 1'b1);
        gate_low = 1;
        tick(); chk_drv("R7 clamp on gate low", STRONG);        // E2
        tick(); chk_bit("R9 fault_n low", fault_n, 1'b0);       // E3
        chk_bit("R9 cmd forced off", cmd_link, 1'b0);
        desat = 0; gate_low = 0;
        tick(); tick(); tick(); tick();                         // E4..E7
        chk_bit("R10 latch holds", fault_n, 1'b0);
        chk_drv("R10 strong while locked", STRONG);
        flt_clr_n = 0;
        tick();                                                 // E8
        chk_bit("R10 cleared", fault_n, 1'b1);
        chk_bit("R10 command returned", cmd_link, 1'b1);
        flt_clr_n = 1; in_pos = 0;
        repeat (3) tick();

        // R8/R10: clear held low, command dropped after fault taken
        in_pos = 1; tick(); tick();
        flt_clr_n = 0; desat = 1;
        tick(); chk_drv("R8 gap", NONE);                        // E0
        tick(); chk_drv("R8 weak", WEAK);                       // E1
        in_pos = 0;
        tick(); chk_drv("R8 strong after command off", STRONG); // E2
        chk_bit("R8 fault_n still high", fault_n, 1'b1);
        tick(); chk_bit("R10 not masked by low clear", fault_n, 1'b0); // E3
        tick(); chk_bit("R10 sync fault still present", fault_n, 1'b0); // E4
        tick(); chk_bit("R8 fault released", fault_n, 1'b1);   // E5
        desat = 0; flt_clr_n = 1;
        repeat (3) tick();

        // R4 with R9: lockout and desat on the same edge
        in_pos = 1; tick(); tick();
        uvlo = 1; desat = 1;
        tick(); chk_drv("R4 gap on combined event", NONE);      // E0
        tick(); chk_drv("R4 strong not weak", STRONG);          // E1
        tick(); chk_drv("R4 strong held", STRONG);              // E2
        tick(); chk_bit("R9 fault still reported", fault_n, 1'b0); // E3
        desat = 0; uvlo = 0; in_pos = 0;
        repeat (4) tick();
        flt_clr_n = 0;
        tick(); chk_bit("R10 release after combined", fault_n, 1'b1);
        flt_clr_n = 1;
        tick(); chk_drv("R2 idle strong", STRONG);

        done = 1'b1;
        finish_run();
    end
endmodule